// File: doc/BRIEF.md
# Bus Cycle Break Match Unit

This block watches every cycle on a processor bus and raises a break interrupt request when a cycle meets a set of programmed conditions. The conditions come from three registers: a break address, a per-bit address mask, and a control word. The control word selects the bus master (CPU, DMA or both), the access kind (instruction fetch, data or both), the direction (read, write or both) and, optionally, an operand size.

A cycle hits when its address equals the break address on every unmasked bit and every enabled condition agrees. The hit is registered, so the request line rises one clock after the matching cycle. The line stays high until the interrupt controller pulses the clear input. Until software programs all three enable pairs (master, kind and direction), the block never requests a break. This is the state after reset.

Top module: `brk_match_unit`

## Requirements
- R1: After reset, `brk_req` is 0, and the address, mask and control registers all read back as 0.
- R2: While `reg_wr` is high on a clock edge, `reg_wdata` is stored in the register chosen by `reg_sel`: 0 is the break address, 1 is the mask, and 2 is the control word in bits 7:0. `reg_rdata` shows the selected register at once, and select 3 reads 0.
- R3: Control bits 7:6 choose the master. 01 matches only CPU cycles (`bus_dma`=0), 10 matches only DMA cycles (`bus_dma`=1), and 11 matches both.
- R4: Control bits 5:4 choose the access kind. 01 matches only instruction fetches (`bus_fetch`=1), 10 matches only data accesses, and 11 matches both.
- R5: Control bits 3:2 choose the direction. 01 matches only reads (`bus_write`=0), 10 matches only writes, and 11 matches both.
- R6: Control bits 1:0 choose the size. 00 ignores size. 01, 10 and 11 match only byte, word and long-word cycles, which `bus_size` also codes as 01, 10 and 11.
- R7: An instruction fetch is always judged as a word access for the size test, whatever value `bus_size` carries.
- R8: If the master, kind or direction field is 00, no break is requested even when every other condition matches.
- R9: An address bit whose mask bit is 1 is left out of the address comparison. Every other bit must equal the break address.
- R10: Only cycles with `bus_valid` high are judged. A matching cycle sets `brk_req` on the clock edge that ends it, so the request is seen one clock after the cycle.
- R11: Once set, `brk_req` stays high until a clock edge with `brk_clr` high.
- R12: When a matching cycle and `brk_clr` fall on the same edge, `brk_req` is set (the match wins).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data of the selected register |
| bus_valid | input | 1 | Bus cycle valid strobe |
| bus_addr | input | AW | Bus cycle address |
| bus_dma | input | 1 | 1 = DMA master, 0 = CPU |
| bus_fetch | input | 1 | 1 = instruction fetch, 0 = data |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Operand size: 01 byte, 10 word, 11 long |
| brk_clr | input | 1 | Clears the request |
| brk_req | output | 1 | Sticky break interrupt request |

## Verification
The two functions that can coincide are setting the sticky request on a new match and clearing it on a `brk_clr` pulse. The random phase drives `brk_clr` on about a quarter of the cycles. It aims half of the bus addresses inside the masked window of the break address, so matches and clears often land on the same edge. Directed steps force the collision both with the request low and with it already high. On every edge the bench judges the result against a model in which a hit sets the request, a clear without a hit drops it, and otherwise the request holds.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int CTRL_W = 8;

  typedef enum logic [1:0] {
    SZ_ANY  = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LONG = 2'b11
  } size_e;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  typedef struct packed {
    logic [1:0] master;
    logic [1:0] kind;
    logic [1:0] dir;
    logic [1:0] size;
  } brk_ctrl_t;
endpackage

// File: rtl/brk_rst_sync.sv
module brk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic [AW-1:0] bar_q,
  output logic [AW-1:0] mask_q,
  output brk_ctrl_t     ctrl_q
);
  logic we_addr, we_mask, we_ctrl;
  logic [AW-1:0] bar_nxt, mask_nxt;
  brk_ctrl_t     ctrl_nxt;

  always_comb begin
    we_addr  = reg_wr && (sel_e'(reg_sel) == SEL_ADDR);
    we_mask  = reg_wr && (sel_e'(reg_sel) == SEL_MASK);
    we_ctrl  = reg_wr && (sel_e'(reg_sel) == SEL_CTRL);
    bar_nxt  = reg_wdata;
    mask_nxt = reg_wdata;
    ctrl_nxt = brk_ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bar_q  <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (we_addr) bar_q  <= bar_nxt;
      if (we_mask) mask_q <= mask_nxt;
      if (we_ctrl) ctrl_q <= ctrl_nxt;
    end
  end

  always_comb begin
    case (sel_e'(reg_sel))
      SEL_ADDR: reg_rdata = bar_q;
      SEL_MASK: reg_rdata = mask_q;
      SEL_CTRL: reg_rdata = {{(AW-CTRL_W){1'b0}}, ctrl_q};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] bar,
  input  logic [AW-1:0] mask,
  input  brk_ctrl_t     ctrl,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_dma,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  output logic          hit
);
  logic [AW-1:0] bit_ok;
  logic addr_ok, master_ok, kind_ok, dir_ok, size_ok, armed;
  size_e eff_size;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign bit_ok[i] = mask[i] | ~(bus_addr[i] ^ bar[i]);
  end

  always_comb begin
    addr_ok   = &bit_ok;
    armed     = (ctrl.master != 2'b00) && (ctrl.kind != 2'b00) && (ctrl.dir != 2'b00);
    master_ok = bus_dma   ? ctrl.master[1] : ctrl.master[0];
    kind_ok   = bus_fetch ? ctrl.kind[0]   : ctrl.kind[1];
    dir_ok    = bus_write ? ctrl.dir[1]    : ctrl.dir[0];
    eff_size  = bus_fetch ? SZ_WORD : size_e'(bus_size);
    size_ok   = (size_e'(ctrl.size) == SZ_ANY) || (size_e'(ctrl.size) == eff_size);
    hit       = bus_valid && armed && master_ok && kind_ok && dir_ok && size_ok && addr_ok;
  end
endmodule

// File: rtl/brk_req_hold.sv
module brk_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr,
  output logic req
);
  logic req_q, req_nxt, req_en;

  always_comb begin
    req_en  = hit | clr;
    req_nxt = hit | (req_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (req_en) req_q <= req_nxt;
  end

  assign req = req_q;
endmodule

// File: rtl/brk_match_unit.sv
module brk_match_unit
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_dma,
  input  logic          bus_fetch,
  input  logic          bus_write,
  input  logic [1:0]    bus_size,
  input  logic          brk_clr,
  output logic          brk_req
);
  logic          rst_sync_n;
  logic [AW-1:0] bar_q, mask_q;
  brk_ctrl_t     ctrl_q;
  logic          hit;

  brk_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  brk_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bar_q(bar_q), .mask_q(mask_q), .ctrl_q(ctrl_q)
  );

  brk_match #(.AW(AW)) u_match (
    .bar(bar_q), .mask(mask_q), .ctrl(ctrl_q), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_dma(bus_dma), .bus_fetch(bus_fetch),
    .bus_write(bus_write), .bus_size(bus_size), .hit(hit)
  );

  brk_req_hold u_hold (
    .clk(clk), .rst_n(rst_sync_n), .hit(hit), .clr(brk_clr), .req(brk_req)
  );
endmodule

// File: rtl/brk_match_unit_chk.sv
module brk_match_unit_chk
  import brk_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      bus_valid,
  input logic      bus_fetch,
  input brk_ctrl_t ctrl,
  input logic      hit,
  input logic      brk_clr,
  input logic      brk_req
);
  AST_HIT_SETS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> brk_req); // R10

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !brk_clr) |=> brk_req); // R11

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_clr && !hit) |=> !brk_req); // R11

  AST_MATCH_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_clr && hit) |=> brk_req); // R12

  AST_RISE_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> $past(hit)); // R10

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> bus_valid); // R10

  AST_HIT_NEEDS_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (ctrl.master != 2'b00 && ctrl.kind != 2'b00 && ctrl.dir != 2'b00)); // R8

  AST_FETCH_IS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && bus_fetch) |-> (ctrl.size == 2'b00 || ctrl.size == 2'b10)); // R7
endmodule

bind brk_match_unit brk_match_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
  .ctrl(ctrl_q), .hit(hit), .brk_clr(brk_clr), .brk_req(brk_req)
);

// File: tb/sim_brk_match_unit.sv
`timescale 1ns/1ps
module sim_brk_match_unit;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [1:0]    reg_sel;
  logic [AW-1:0] reg_wdata;
  logic [AW-1:0] reg_rdata;
  logic          bus_valid;
  logic [AW-1:0] bus_addr;
  logic          bus_dma, bus_fetch, bus_write;
  logic [1:0]    bus_size;
  logic          brk_clr;
  logic          brk_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_bar, m_mask;
  logic [7:0]    m_ctrl;
  logic          m_req;

  always #2.5 clk = ~clk;

  brk_match_unit #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_dma(bus_dma), .bus_fetch(bus_fetch),
    .bus_write(bus_write), .bus_size(bus_size), .brk_clr(brk_clr),
    .brk_req(brk_req)
  );

  function automatic bit f_hit(logic [7:0] c, logic [AW-1:0] b, logic [AW-1:0] m,
                               logic v, logic [AW-1:0] a, logic d, logic f,
                               logic w, logic [1:0] s);
    logic [1:0] es;
    bit ok;
    ok = v;
    if (c[7:6] == 2'b00 || c[5:4] == 2'b00 || c[3:2] == 2'b00) ok = 0;
    if (d) begin if (!c[7]) ok = 0; end else begin if (!c[6]) ok = 0; end
    if (f) begin if (!c[4]) ok = 0; end else begin if (!c[5]) ok = 0; end
    if (w) begin if (!c[3]) ok = 0; end else begin if (!c[2]) ok = 0; end
    es = f ? 2'b10 : s;
    if (c[1:0] != 2'b00 && c[1:0] != es) ok = 0;
    for (int i = 0; i < AW; i++)
      if (!m[i] && (a[i] != b[i])) ok = 0;
    return ok;
  endfunction

  task automatic check(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(logic [1:0] sel, logic [AW-1:0] data);
    @(negedge clk);
    bus_valid = 0; brk_clr = 0;
    reg_wr = 1; reg_sel = sel; reg_wdata = data;
    @(posedge clk); #1;
    reg_wr = 0;
    case (sel)
      2'd0: m_bar = data;
      2'd1: m_mask = data;
      2'd2: m_ctrl = data[7:0];
      default: ;
    endcase
  endtask

  task automatic drive(logic v, logic [AW-1:0] a, logic d, logic f, logic w,
                       logic [1:0] s, logic c);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_dma = d; bus_fetch = f;
    bus_write = w; bus_size = s; brk_clr = c;
  endtask

  task automatic probe(logic v, logic [AW-1:0] a, logic d, logic f, logic w,
                       logic [1:0] s, bit exp, string tag);
    drive(0, '0, 0, 0, 0, 2'b00, 1);
    @(posedge clk); #1;
    drive(v, a, d, f, w, s, 0);
    @(posedge clk); #1;
    check(brk_req == exp, tag, AW'(brk_req), AW'(exp));
    m_req = exp;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] B;
    void'($urandom(32'h5eed_1234));
    rst_n = 0; reg_wr = 0; reg_sel = 0; reg_wdata = '0;
    bus_valid = 0; bus_addr = '0; bus_dma = 0; bus_fetch = 0;
    bus_write = 0; bus_size = 0; brk_clr = 0;
    m_bar = '0; m_mask = '0; m_ctrl = '0; m_req = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (4) @(posedge clk); #1;

    // R1 reset state
    check(brk_req == 0, "R1 req", AW'(brk_req), '0);
    for (int s = 0; s < 3; s++) begin
      reg_sel = 2'(s); #1;
      check(reg_rdata == '0, "R1 reg", reg_rdata, '0);
    end
    // R8 reset control word: a cycle at the reset address never hits
    probe(1, '0, 0, 0, 0, 2'b01, 0, "R8 reset");

    // R2 register access
    B = 32'h1000_0040;
    wreg(2'd0, B);
    wreg(2'd1, 32'h0000_000F);
    wreg(2'd2, 32'hFFFF_FFFC);
    reg_sel = 2'd0; #1; check(reg_rdata == B, "R2 addr", reg_rdata, B);
    reg_sel = 2'd1; #1; check(reg_rdata == 32'hF, "R2 mask", reg_rdata, 32'hF);
    reg_sel = 2'd2; #1; check(reg_rdata == 32'hFC, "R2 ctrl", reg_rdata, 32'hFC);
    reg_sel = 2'd3; #1; check(reg_rdata == '0, "R2 none", reg_rdata, '0);

    // R8 any disabled pair suppresses
    wreg(2'd2, 32'h3C); probe(1, B, 0, 0, 0, 2'b11, 0, "R8 master00");
    wreg(2'd2, 32'hCC); probe(1, B, 0, 0, 0, 2'b11, 0, "R8 kind00");
    wreg(2'd2, 32'hF0); probe(1, B, 0, 0, 0, 2'b11, 0, "R8 dir00");
    wreg(2'd2, 32'hFC); probe(1, B, 0, 0, 0, 2'b11, 1, "R8 armed");

    // R9 mask
    probe(1, B ^ 32'h5,   0, 0, 1, 2'b01, 1, "R9 masked bits");
    probe(1, B ^ 32'h100, 0, 0, 1, 2'b01, 0, "R9 unmasked bit");

    // R10 valid gating and latency
    probe(0, B, 0, 0, 0, 2'b01, 0, "R10 invalid");
    drive(0, '0, 0, 0, 0, 2'b00, 1); @(posedge clk); #1;
    drive(1, B, 0, 0, 0, 2'b01, 0); #1;
    check(brk_req == 0, "R10 not before edge", AW'(brk_req), '0);
    @(posedge clk); #1;
    check(brk_req == 1, "R10 one clock after", AW'(brk_req), 1);

    // R3 master
    wreg(2'd2, 32'h7C);
    probe(1, B, 0, 0, 0, 2'b01, 1, "R3 cpu only cpu");
    probe(1, B, 1, 0, 0, 2'b01, 0, "R3 cpu only dma");
    wreg(2'd2, 32'hBC);
    probe(1, B, 1, 0, 0, 2'b01, 1, "R3 dma only dma");
    probe(1, B, 0, 0, 0, 2'b01, 0, "R3 dma only cpu");

    // R4 kind
    wreg(2'd2, 32'hDC);
    probe(1, B, 0, 1, 0, 2'b10, 1, "R4 fetch only fetch");
    probe(1, B, 0, 0, 0, 2'b10, 0, "R4 fetch only data");
    wreg(2'd2, 32'hEC);
    probe(1, B, 0, 0, 0, 2'b10, 1, "R4 data only data");
    probe(1, B, 0, 1, 0, 2'b10, 0, "R4 data only fetch");

    // R5 direction
    wreg(2'd2, 32'hF4);
    probe(1, B, 0, 0, 0, 2'b01, 1, "R5 read only read");
    probe(1, B, 0, 0, 1, 2'b01, 0, "R5 read only write");
    wreg(2'd2, 32'hF8);
    probe(1, B, 0, 0, 1, 2'b01, 1, "R5 write only write");
    probe(1, B, 0, 0, 0, 2'b01, 0, "R5 write only read");

    // R6 size
    wreg(2'd2, 32'hFD);
    probe(1, B, 0, 0, 0, 2'b01, 1, "R6 byte byte");
    probe(1, B, 0, 0, 0, 2'b10, 0, "R6 byte word");
    wreg(2'd2, 32'hFF);
    probe(1, B, 1, 0, 1, 2'b11, 1, "R6 long long");

    // R7 fetch is word
    wreg(2'd2, 32'hFE);
    probe(1, B, 0, 1, 0, 2'b11, 1, "R7 word fetch on long bus");
    wreg(2'd2, 32'hFF);
    probe(1, B, 0, 1, 0, 2'b11, 0, "R7 long vs fetch");
    wreg(2'd2, 32'hFD);
    probe(1, B, 0, 1, 0, 2'b01, 0, "R7 byte vs fetch");

    // R11 sticky, R12 collision
    wreg(2'd2, 32'hFC);
    probe(1, B, 0, 0, 0, 2'b01, 1, "R11 set");
    drive(0, '0, 0, 0, 0, 2'b00, 0);
    repeat (3) @(posedge clk); #1;
    check(brk_req == 1, "R11 held", AW'(brk_req), 1);
    drive(0, '0, 0, 0, 0, 2'b00, 1); @(posedge clk); #1;
    check(brk_req == 0, "R11 cleared", AW'(brk_req), 0);
    drive(1, B, 0, 0, 0, 2'b01, 1); @(posedge clk); #1;
    check(brk_req == 1, "R12 match wins from low", AW'(brk_req), 1);
    drive(1, B, 0, 0, 0, 2'b01, 1); @(posedge clk); #1;
    check(brk_req == 1, "R12 match wins from high", AW'(brk_req), 1);
    m_req = 1;

    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic v, d, f, w, c, e, h;
      logic [1:0] s;
      logic [AW-1:0] a;
      if ((n % 64) == 0) begin
        wreg(2'd0, $urandom);
        wreg(2'd1, $urandom & 32'h0000_0FFF);
        wreg(2'd2, {24'h0, ($urandom % 8 == 0) ? 8'($urandom) : (8'($urandom) | 8'h54)});
      end
      v = ($urandom % 4) != 0;
      d = 1'($urandom); f = 1'($urandom); w = 1'($urandom);
      s = 2'(($urandom % 3) + 1);
      c = ($urandom % 4) == 0;
      a = ($urandom % 2) ? (m_bar ^ ($urandom & m_mask)) : $urandom;
      h = f_hit(m_ctrl, m_bar, m_mask, v, a, d, f, w, s);
      e = h | (m_req & ~c);
      drive(v, a, d, f, w, s, c);
      @(posedge clk); #1;
      check(brk_req == e, "R10 R11 R12 random", AW'(brk_req), AW'(e));
      m_req = e;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule